// File: doc/BRIEF.md
# Two-Register Memory Access Sequencer

This block stands between a processing unit and a word-addressed memory of 2^ADDR_W locations, each DATA_W bits wide. Every memory transaction passes through two registers: an address register that drives the memory address bus, and a data register that drives the memory write bus and catches read words. The processor side raises a one-cycle request with a direction bit, an address and, for writes, a data word. The block then loads the two registers in the order the operation needs, raises the matching strobe, and holds that strobe for as many cycles as the memory needs.

A load writes the address register first and then asserts the read strobe. The word the memory returns lands in the data register and is presented on the read-data output. A store writes the data register first, the address register on the following cycle, and asserts the write strobe only after both registers hold their final values. In both cases the memory ends the access by raising its ready input, and the block answers with a single-cycle completion pulse. Both registers keep their contents between accesses.

Top module: `mem_if_unit`

## Requirements
- R1: A synchronous active-high reset, whether at start-up or in the middle of an access, leaves the unit idle on the next clock. After it, `mem_rd`, `mem_wr` and `done` are 0, and `mem_addr`, `mem_wdata` and `rdata` are all zero.
- R2: A load is accepted when `req`=1 and `we`=0 while the unit is idle. In the cycle after acceptance, `mem_addr` already equals the requested address, `mem_rd`=1 and `mem_wr`=0.
- R3: A store is accepted when `req`=1 and `we`=1 while the unit is idle. In the cycle after acceptance, `mem_wdata` equals the request data, `mem_addr` still holds its previous value and neither strobe is high. One cycle later, `mem_addr` equals the request address and `mem_wr`=1. While the write strobe is held, both buses stay stable.
- R4: A strobe stays high for every cycle in which `mem_ready` is sampled 0. It falls in the cycle after `mem_ready` is sampled 1 while the strobe is high.
- R5: `done` is high for exactly one cycle, the cycle after `mem_ready` is sampled high during a strobe. With W cycles of `mem_ready`=0 in the strobe, a load signals `done` 2+W cycles after acceptance and a store signals it 3+W cycles after acceptance.
- R6: During the `done` cycle of a load, `rdata` equals the word that was on `mem_rdata` when ready was sampled. `rdata` then keeps that value through any number of stores, until the next load completes.
- R7: A request raised while an access is in progress is ignored. It starts no strobe and does not alter `mem_addr` or `mem_wdata`.
- R8: `mem_ready` is ignored while neither strobe is high. It produces no `done` and no strobe.
- R9: Between accesses, `mem_addr` keeps the last address loaded. `mem_wdata` keeps the last word placed in the data register: the store data after a store, or the read word after a load.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled only while idle |
| we | input | 1 | Request direction: 1 store, 0 load |
| addr | input | ADDR_W | Request address |
| wdata | input | DATA_W | Store data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word returned by the last completed load |
| mem_addr | output | ADDR_W | Address register contents, to the memory |
| mem_wdata | output | DATA_W | Data register contents, to the memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | DATA_W | Word from the memory |
| mem_ready | input | 1 | Memory completion indication |

## Verification
The hardest situation to reach from the ports is a request that arrives while an access is still in flight, combined with a memory that holds off completion. The direct stimulus would simply be accepted, because the unit is then idle. The bench starts a load, keeps `mem_ready` low for several cycles, and during that wait raises a store request to a different address. It drops that request in the same cycle it finally grants ready, so the request is gone before the unit returns to idle. It then confirms that no write strobe ever follows and that both buses keep the load's values. A reset applied while the write strobe is held is reached the same way, by withholding ready.

// File: rtl/mem_if_pkg.sv
package mem_if_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_LD_READ = 3'd1,
    SQ_ST_ADDR = 3'd2,
    SQ_ST_WRIT = 3'd3,
    SQ_FINISH  = 3'd4
  } seq_state_t;

  // Successor state of the access sequencer.
  function automatic seq_state_t seq_next(input seq_state_t cur, input logic req,
                                          input logic we, input logic ready);
    seq_state_t nxt;
    nxt = cur;
    case (cur)
      SQ_IDLE:    if (req) nxt = we ? SQ_ST_ADDR : SQ_LD_READ;
      SQ_LD_READ: if (ready) nxt = SQ_FINISH;
      SQ_ST_ADDR: nxt = SQ_ST_WRIT;
      SQ_ST_WRIT: if (ready) nxt = SQ_FINISH;
      SQ_FINISH:  nxt = SQ_IDLE;
      default:    nxt = SQ_IDLE;
    endcase
    return nxt;
  endfunction

  // Address register source: pending store address or live request address.
  function automatic logic [63:0] pick_word(input logic use_alt, input logic [63:0] primary,
                                            input logic [63:0] alternate);
    return use_alt ? alternate : primary;
  endfunction

endpackage

// File: rtl/mem_if_field_reg.sv
module mem_if_field_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/mem_if_seq.sv
module mem_if_seq
  import mem_if_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic we,
  input  logic mem_ready,
  output logic accept_ld,
  output logic accept_st,
  output logic mar_load,
  output logic mar_from_pend,
  output logic mdr_load,
  output logic mdr_from_mem,
  output logic rdata_load,
  output logic mem_rd,
  output logic mem_wr,
  output logic done
);
  seq_state_t state_q, state_d;
  logic       op_load_q;
  logic       idle;

  assign idle      = (state_q == SQ_IDLE);
  assign accept_ld = idle && req && !we;
  assign accept_st = idle && req && we;
  assign state_d   = seq_next(state_q, req, we, mem_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      op_load_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_ld || accept_st) op_load_q <= accept_ld;
    end
  end

  // Load: address register on acceptance. Store: data first, address next cycle.
  assign mar_load      = accept_ld || (state_q == SQ_ST_ADDR);
  assign mar_from_pend = (state_q == SQ_ST_ADDR);
  assign mdr_from_mem  = (state_q == SQ_LD_READ);
  assign mdr_load      = accept_st || (mdr_from_mem && mem_ready);

  assign mem_rd     = (state_q == SQ_LD_READ);
  assign mem_wr     = (state_q == SQ_ST_WRIT);
  assign done       = (state_q == SQ_FINISH);
  assign rdata_load = done && op_load_q;
endmodule

// File: rtl/mem_if_unit.sv
module mem_if_unit
  import mem_if_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int unsigned WIDE = 64;

  logic accept_ld, accept_st, mar_load, mar_from_pend;
  logic mdr_load, mdr_from_mem, rdata_load;
  logic [ADDR_W-1:0] pend_addr, mar_d;
  logic [DATA_W-1:0] mdr_d, rdata_q;
  logic [WIDE-1:0]   mar_wide, mdr_wide;

  mem_if_seq u_seq (
    .clk(clk), .rst(rst), .req(req), .we(we), .mem_ready(mem_ready),
    .accept_ld(accept_ld), .accept_st(accept_st),
    .mar_load(mar_load), .mar_from_pend(mar_from_pend),
    .mdr_load(mdr_load), .mdr_from_mem(mdr_from_mem), .rdata_load(rdata_load),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done)
  );

  // Store address parked here until its turn to enter the address register.
  mem_if_field_reg #(.W(ADDR_W)) u_pend (
    .clk(clk), .rst(rst), .ld(accept_st), .d(addr), .q(pend_addr)
  );

  assign mar_wide = pick_word(mar_from_pend, WIDE'(addr), WIDE'(pend_addr));
  assign mar_d    = mar_wide[ADDR_W-1:0];

  mem_if_field_reg #(.W(ADDR_W)) u_mar (
    .clk(clk), .rst(rst), .ld(mar_load), .d(mar_d), .q(mem_addr)
  );

  assign mdr_wide = pick_word(mdr_from_mem, WIDE'(wdata), WIDE'(mem_rdata));
  assign mdr_d    = mdr_wide[DATA_W-1:0];

  mem_if_field_reg #(.W(DATA_W)) u_mdr (
    .clk(clk), .rst(rst), .ld(mdr_load), .d(mdr_d), .q(mem_wdata)
  );

  // Read result register: copied from the data register at load completion.
  mem_if_field_reg #(.W(DATA_W)) u_rdq (
    .clk(clk), .rst(rst), .ld(rdata_load), .d(mem_wdata), .q(rdata_q)
  );

  assign rdata = rdata_load ? mem_wdata : rdata_q;

  logic unused_ok;
  assign unused_ok = ^{mar_wide[WIDE-1:ADDR_W], mdr_wide[WIDE-1:DATA_W], accept_ld};
endmodule

// File: rtl/mem_if_unit_chk.sv
module mem_if_unit_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic              done,
  input logic [DATA_W-1:0] rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mar_load,
  input logic              mdr_load
);
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> mem_rd);

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> mem_wr);

  assert_strobe_drop_R4: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && mem_ready) |=> !(mem_rd || mem_wr));

  assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past((mem_rd || mem_wr) && mem_ready));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_rd_after_addr_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> $past(mar_load));

  assert_st_order_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> ($past(mar_load) && $past(mdr_load, 2)));

  assert_wr_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_rdata_change_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> done);
endmodule

bind mem_if_unit mem_if_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
  .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mar_load(mar_load), .mdr_load(mdr_load)
);

// File: tb/mem_if_unit_test.sv
module mem_if_unit_test;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, req, we, done, mem_rd, mem_wr, mem_ready;
  logic [AW-1:0] addr, mem_addr;
  logic [DW-1:0] wdata, rdata, mem_wdata, mem_rdata;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  mem_if_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Load with W wait cycles; done expected 2+W cycles after acceptance.
  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] word, input int w);
    int cyc;
    req = 1'b1; we = 1'b0; addr = a;
    step(); cyc = 1;
    req = 1'b0; addr = ~a;
    expect_eq("R2 addr before strobe", mem_addr, a);
    expect_eq("R2 read strobe", mem_rd, 1'b1);
    expect_eq("R10 no write on load", mem_wr, 1'b0);
    for (int i = 0; i < w; i++) begin
      mem_ready = 1'b0;
      expect_eq("R4 read held", mem_rd, 1'b1);
      expect_eq("R5 no early done", done, 1'b0);
      step(); cyc++;
    end
    mem_ready = 1'b1; mem_rdata = word;
    step(); cyc++;
    mem_ready = 1'b0; mem_rdata = ~word;
    expect_eq("R5 load done timing", {31'd0, done}, {31'd0, (cyc == 2 + w)});
    expect_eq("R4 read dropped", mem_rd, 1'b0);
    expect_eq("R6 read word", rdata, word);
    step();
    expect_eq("R5 done one cycle", done, 1'b0);
    expect_eq("R6 read word held", rdata, word);
    expect_eq("R9 data reg holds read word", mem_wdata, word);
    expect_eq("R9 addr reg holds", mem_addr, a);
  endtask

  // Store with W wait cycles; done expected 3+W cycles after acceptance.
  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input int w);
    logic [AW-1:0] prev_a;
    logic [DW-1:0] prev_r;
    int cyc;
    prev_a = mem_addr; prev_r = rdata;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    step(); cyc = 1;
    req = 1'b0; addr = ~a; wdata = ~d;
    expect_eq("R3 data first", mem_wdata, d);
    expect_eq("R3 addr not yet", mem_addr, prev_a);
    expect_eq("R3 no strobe yet", {mem_rd, mem_wr}, 2'b00);
    step(); cyc++;
    expect_eq("R3 addr second", mem_addr, a);
    expect_eq("R3 write strobe", mem_wr, 1'b1);
    for (int i = 0; i < w; i++) begin
      mem_ready = 1'b0;
      expect_eq("R4 write held", mem_wr, 1'b1);
      expect_eq("R10 no read on store", mem_rd, 1'b0);
      step(); cyc++;
    end
    mem_ready = 1'b1;
    step(); cyc++;
    mem_ready = 1'b0;
    expect_eq("R5 store done timing", {31'd0, done}, {31'd0, (cyc == 3 + w)});
    expect_eq("R4 write dropped", mem_wr, 1'b0);
    expect_eq("R6 rdata kept over store", rdata, prev_r);
    step();
    expect_eq("R5 done one cycle", done, 1'b0);
    expect_eq("R9 addr reg holds", mem_addr, a);
    expect_eq("R9 data reg holds", mem_wdata, d);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    step(); step(); step();
    expect_eq("R1 strobes after reset", {mem_rd, mem_wr, done}, 3'b000);
    expect_eq("R1 addr after reset", mem_addr, '0);
    expect_eq("R1 data after reset", mem_wdata, '0);
    expect_eq("R1 rdata after reset", rdata, '0);
    rst = 1'b0;
    step();
  endtask

  task automatic test_busy_ignore();
    req = 1'b1; we = 1'b0; addr = 16'h0A0A;
    step();
    req = 1'b1; we = 1'b1; addr = 16'h7777; wdata = 16'h3131;
    mem_ready = 1'b0;
    step(); step();
    expect_eq("R7 read still held", mem_rd, 1'b1);
    expect_eq("R7 addr unchanged while busy", mem_addr, 16'h0A0A);
    req = 1'b0; mem_ready = 1'b1; mem_rdata = 16'h9999;
    step();
    mem_ready = 1'b0;
    expect_eq("R7 load completes", done, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step();
      expect_eq("R7 no strobe from ignored request", {mem_rd, mem_wr, done}, 3'b000);
      expect_eq("R7 addr kept", mem_addr, 16'h0A0A);
      expect_eq("R7 data kept", mem_wdata, 16'h9999);
    end
  endtask

  task automatic test_stray_ready();
    mem_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      expect_eq("R8 stray ready ignored", {mem_rd, mem_wr, done}, 3'b000);
    end
    mem_ready = 1'b0;
    step();
    expect_eq("R8 rdata unchanged", rdata, 16'h9999);
  endtask

  task automatic test_mid_reset();
    req = 1'b1; we = 1'b1; addr = 16'h4444; wdata = 16'h5555;
    step();
    req = 1'b0; mem_ready = 1'b0;
    step();
    expect_eq("R3 write before reset", mem_wr, 1'b1);
    rst = 1'b1;
    step();
    expect_eq("R1 reset mid access strobes", {mem_rd, mem_wr, done}, 3'b000);
    expect_eq("R1 reset mid access addr", mem_addr, '0);
    expect_eq("R1 reset mid access data", mem_wdata, '0);
    step();
    rst = 1'b0;
    step(); step();
    expect_eq("R1 idle after reset", {mem_rd, mem_wr, done}, 3'b000);
  endtask

  initial begin
    rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    mem_rdata = '0; mem_ready = 1'b0;
    step();
    test_reset();
    do_load(16'h1234, 16'hBEEF, 0);
    do_load(16'hFFFF, 16'h0001, 3);
    do_store(16'h0042, 16'hCAFE, 0);
    do_store(16'h0000, 16'h5A5A, 4);
    expect_eq("R6 rdata after stores", rdata, 16'h0001);
    test_busy_ignore();
    test_stray_ready();
    test_mid_reset();
    do_load(16'h8001, 16'h7E7E, 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule